// File: doc/BRIEF.md
# Bounds-Check Trap Sequencer

This block runs the execution phase of a register bounds-check instruction. The operand fetch has already happened. The block takes a signed data-register value and an upper-bound operand at a chosen operand size, together with the current program counter. It then issues one instruction prefetch and waits for that prefetch to be acknowledged. The comparison result decides what happens next. The block inserts a number of idle bus cycles that depends on the outcome. After those cycles it either finishes the instruction with a one-cycle done strobe, or raises the bounds-check exception toward the exception entry sequencer. The exception request carries the vector number and the address of the faulting instruction.

Work enters through a valid/ready pair. `start_ready` is high only while the block is idle. A command is taken on a clock edge where `start_valid` and `start_ready` are both high. While the block is busy, `start_valid` is ignored and no back-pressure reaches the operand inputs. The exception request works the same way on the output side. `exc_valid` stays high until `exc_ready` is seen, and `exc_vector` and `exc_addr` do not change while it waits. The prefetch uses a req/ack pair: `pf_req` stays high until `pf_ack` is returned.

Top module: `chk_trap_seq`

## Requirements
- R1: A command is accepted only on an edge with `start_valid` and `start_ready` both high. `start_ready` is high only when the block is idle. A `start_valid` raised while the block is busy changes nothing: no new prefetch starts, and the captured operands and address are kept.
- R2: Each accepted command produces exactly one prefetch request. `pf_req` rises in the cycle after acceptance and stays high until the edge that samples `pf_ack` high.
- R3: `op_size` selects the compare width: 0 is byte (bits 7:0), 1 is word (bits 15:0), and 2 or 3 is long (all bits). Both operands are sign-extended from the selected width, and their upper bits are ignored.
- R4: In range (0 <= value <= bound): after the prefetch, `bus_idle` is high for exactly 3 cycles. `done` is then high for one cycle. No exception is raised and `flag_we` stays low.
- R5: Above bound (value > bound): after the prefetch, `bus_idle` is high for exactly 2 cycles and then the exception is requested. `flag_we` pulses once with `flag_n` = 0.
- R6: Below zero (value < 0, not above bound): after the prefetch, `bus_idle` is high for exactly 3 cycles and then the exception is requested. `flag_we` pulses once with `flag_n` = 1.
- R7: When the value is both negative and above a negative bound, the above-bound outcome (R5) applies.
- R8: A trap reports `exc_vector` = 6 and `exc_addr` = the command's `cur_pc` minus 4.
- R9: `exc_valid` stays high, with `exc_vector` and `exc_addr` stable, until an edge with `exc_ready` high. The block then returns to idle.
- R10: `done` is never high in two consecutive cycles, and it is never high together with `exc_valid`.
- R11: After reset, `start_ready` is high and `pf_req`, `bus_idle`, `flag_we`, `exc_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Command valid |
| start_ready | output | 1 | Block idle, command can be taken |
| op_value | input | DATA_W | Data-register value to check |
| op_bound | input | DATA_W | Upper bound operand |
| op_size | input | 2 | Compare width: 0 byte, 1 word, 2/3 long |
| cur_pc | input | ADDR_W | Program counter at command time |
| pf_req | output | 1 | Prefetch request |
| pf_ack | input | 1 | Prefetch completed |
| bus_idle | output | 1 | Idle bus cycle in progress |
| flag_we | output | 1 | Negative-flag write strobe |
| flag_n | output | 1 | Negative-flag value |
| exc_valid | output | 1 | Exception request |
| exc_ready | input | 1 | Exception sequencer takes the request |
| exc_vector | output | VEC_W | Exception vector number |
| exc_addr | output | ADDR_W | Faulting instruction address |
| done | output | 1 | Instruction completed without trap |

## Verification
Some properties are checked by assertions on every cycle. These are the handshake rules: idle-only readiness, the prefetch request held until acknowledged, and the exception request held stable until taken. They also cover the single-cycle done pulse, the idle counter counting down one step per cycle, and the rule that an exception request always follows an idle cycle. Other behaviour can only be shown by the bench's scenarios, where a scoreboard predicts the outcome of each command from its operands. These are the exact idle counts for each outcome, the over-before-under priority, size-dependent sign extension, the flag value, the reported address, and the ignoring of a start pulse while the block is busy.

// File: rtl/chk_pkg.sv
package chk_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_t;

  typedef enum logic [1:0] {
    OUT_OK    = 2'd0,
    OUT_OVER  = 2'd1,
    OUT_UNDER = 2'd2
  } outcome_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PREFETCH = 3'd1,
    ST_WAIT     = 3'd2,
    ST_DONE     = 3'd3,
    ST_TRAP     = 3'd4
  } state_t;
endpackage

// File: rtl/chk_sext.sv
module chk_sext #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] dout
);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  logic [DATA_W-1:0] ext_b;
  logic [DATA_W-1:0] ext_w;

  assign ext_b = {{(DATA_W-BYTE_W){din[BYTE_W-1]}}, din[BYTE_W-1:0]};

  // A datapath no wider than a word treats word as full width.
  generate
    if (DATA_W > WORD_W) begin : g_word
      assign ext_w = {{(DATA_W-WORD_W){din[WORD_W-1]}}, din[WORD_W-1:0]};
    end else begin : g_word_full
      assign ext_w = din;
    end
  endgenerate

  always_comb begin
    case (size)
      2'd0:    dout = ext_b;
      2'd1:    dout = ext_w;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/chk_cmp.sv
module chk_cmp
  import chk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] bound,
  input  logic [1:0]        size,
  output outcome_t          outcome
);
  logic [DATA_W-1:0] raw [2];
  logic [DATA_W-1:0] ext [2];
  logic              is_over;
  logic              is_under;

  assign raw[0] = value;
  assign raw[1] = bound;

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_ext
      chk_sext #(.DATA_W(DATA_W)) u_sext (
        .din  (raw[gi]),
        .size (size),
        .dout (ext[gi])
      );
    end
  endgenerate

  assign is_under = ext[0][DATA_W-1];
  assign is_over  = $signed(ext[0]) > $signed(ext[1]);

  // The above-bound case wins when both conditions hold.
  always_comb begin
    if (is_over)       outcome = OUT_OVER;
    else if (is_under) outcome = OUT_UNDER;
    else               outcome = OUT_OK;
  end
endmodule

// File: rtl/chk_idle_ctr.sv
module chk_idle_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (run && cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign last = (cnt == CNT_W'(1));

  // R4 R5 R6: idle window shrinks by one each running cycle
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/chk_ctrl.sv
module chk_ctrl
  import chk_pkg::*;
#(
  parameter int IDLE_OK    = 3,
  parameter int IDLE_OVER  = 2,
  parameter int IDLE_UNDER = 3,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic             pf_ack,
  input  logic             exc_ready,
  input  outcome_t         outcome,
  input  logic             cnt_last,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_run,
  output logic             start_ready,
  output logic             pf_req,
  output logic             bus_idle,
  output logic             flag_we,
  output logic             flag_n,
  output logic             exc_valid,
  output logic             done
);
  state_t   state, state_nx;
  outcome_t result_q;

  assign start_ready = (state == ST_IDLE);
  assign accept      = start_ready && start_valid;
  assign pf_req      = (state == ST_PREFETCH);
  assign bus_idle    = (state == ST_WAIT);
  assign exc_valid   = (state == ST_TRAP);
  assign done        = (state == ST_DONE);
  assign cnt_load    = pf_req && pf_ack;
  assign cnt_run     = bus_idle;

  always_comb begin
    case (outcome)
      OUT_OVER:  cnt_val = CNT_W'(IDLE_OVER);
      OUT_UNDER: cnt_val = CNT_W'(IDLE_UNDER);
      default:   cnt_val = CNT_W'(IDLE_OK);
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:     if (start_valid) state_nx = ST_PREFETCH;
      ST_PREFETCH: if (pf_ack)      state_nx = ST_WAIT;
      ST_WAIT:     if (cnt_last)    state_nx = (result_q == OUT_OK) ? ST_DONE : ST_TRAP;
      ST_DONE:                      state_nx = ST_IDLE;
      ST_TRAP:     if (exc_ready)   state_nx = ST_IDLE;
      default:                      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      result_q <= OUT_OK;
      flag_we  <= 1'b0;
      flag_n   <= 1'b0;
    end else begin
      state   <= state_nx;
      flag_we <= 1'b0;
      if (cnt_load) begin
        result_q <= outcome;
        if (outcome != OUT_OK) begin
          flag_we <= 1'b1;
          flag_n  <= (outcome == OUT_UNDER);
        end
      end
    end
  end

  // R1: readiness only while nothing is in flight
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (!pf_req && !bus_idle && !exc_valid && !done));
  // R2: prefetch request held until acknowledged
  a_r2_pf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req && !pf_ack) |=> pf_req);
  // R10: done is a single-cycle pulse, never with a trap
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc_valid));
  // R5 R6: a trap request is always preceded by an idle cycle
  a_r5_trap_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_valid) |-> $past(bus_idle));
endmodule

// File: rtl/chk_trap_seq.sv
module chk_trap_seq
  import chk_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int VEC_W      = 8,
  parameter int CHK_VECTOR = 6,
  parameter int PC_REWIND  = 4,
  parameter int IDLE_OK    = 3,
  parameter int IDLE_OVER  = 2,
  parameter int IDLE_UNDER = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [DATA_W-1:0] op_value,
  input  logic [DATA_W-1:0] op_bound,
  input  logic [1:0]        op_size,
  input  logic [ADDR_W-1:0] cur_pc,
  output logic              pf_req,
  input  logic              pf_ack,
  output logic              bus_idle,
  output logic              flag_we,
  output logic              flag_n,
  output logic              exc_valid,
  input  logic              exc_ready,
  output logic [VEC_W-1:0]  exc_vector,
  output logic [ADDR_W-1:0] exc_addr,
  output logic              done
);
  localparam int MAX_A    = (IDLE_OK > IDLE_OVER) ? IDLE_OK : IDLE_OVER;
  localparam int MAX_IDLE = (MAX_A > IDLE_UNDER) ? MAX_A : IDLE_UNDER;
  localparam int CNT_W    = $clog2(MAX_IDLE + 1);

  logic [DATA_W-1:0] value_q, bound_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  outcome_t          outcome;
  logic              accept, cnt_load, cnt_run, cnt_last;
  logic [CNT_W-1:0]  cnt_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      bound_q <= '0;
      size_q  <= 2'd0;
      addr_q  <= '0;
    end else if (accept) begin
      value_q <= op_value;
      bound_q <= op_bound;
      size_q  <= op_size;
      addr_q  <= cur_pc - ADDR_W'(PC_REWIND);
    end
  end

  assign exc_addr   = addr_q;
  assign exc_vector = VEC_W'(CHK_VECTOR);

  chk_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value   (value_q),
    .bound   (bound_q),
    .size    (size_q),
    .outcome (outcome)
  );

  chk_idle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .run      (cnt_run),
    .last     (cnt_last)
  );

  chk_ctrl #(
    .IDLE_OK    (IDLE_OK),
    .IDLE_OVER  (IDLE_OVER),
    .IDLE_UNDER (IDLE_UNDER),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .pf_ack      (pf_ack),
    .exc_ready   (exc_ready),
    .outcome     (outcome),
    .cnt_last    (cnt_last),
    .accept      (accept),
    .cnt_load    (cnt_load),
    .cnt_val     (cnt_val),
    .cnt_run     (cnt_run),
    .start_ready (start_ready),
    .pf_req      (pf_req),
    .bus_idle    (bus_idle),
    .flag_we     (flag_we),
    .flag_n      (flag_n),
    .exc_valid   (exc_valid),
    .done        (done)
  );

  // R9: pending trap keeps its payload until taken
  a_r9_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_ready) |=> (exc_valid && $stable(exc_addr) && $stable(exc_vector)));
  // R1: captured address cannot move while a command is in flight
  a_r1_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ready) |=> $stable(exc_addr));
endmodule

// File: tb/chk_trap_seq_tb.sv
module chk_trap_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] op_value = '0, op_bound = '0, cur_pc = '0;
  logic [1:0]  op_size = 2'd2;
  logic        pf_req, pf_ack = 1'b0;
  logic        bus_idle, flag_we, flag_n, exc_valid, exc_ready = 1'b0, done;
  logic [7:0]  exc_vector;
  logic [31:0] exc_addr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          trap;
    int          idles;
    bit          fn;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  chk_trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .op_value(op_value), .op_bound(op_bound), .op_size(op_size), .cur_pc(cur_pc),
    .pf_req(pf_req), .pf_ack(pf_ack), .bus_idle(bus_idle), .flag_we(flag_we),
    .flag_n(flag_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
    .exc_vector(exc_vector), .exc_addr(exc_addr), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic signed [31:0] sext(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return {{24{d[7]}}, d[7:0]};
    if (sz == 2'd1) return {{16{d[15]}}, d[15:0]};
    return d;
  endfunction

  // Driver: predicts the outcome and pushes it to the scoreboard
  task automatic run_chk(input logic [31:0] v, input logic [31:0] b, input logic [1:0] sz,
                         input logic [31:0] pc, input int pfd, input int ackd,
                         input string tag, input bit poke);
    exp_t e;
    logic signed [31:0] sv, sb_;
    sv = sext(v, sz);
    sb_ = sext(b, sz);
    e.tag = tag;
    e.addr = pc - 32'd4;
    if (sv > sb_)      begin e.trap = 1; e.idles = 2; e.fn = 0; end
    else if (sv < 0)   begin e.trap = 1; e.idles = 3; e.fn = 1; end
    else               begin e.trap = 0; e.idles = 3; e.fn = 0; end
    sb.push_back(e);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1; op_value = v; op_bound = b; op_size = sz; cur_pc = pc;
    @(negedge clk);
    start_valid = 0;
    repeat (pfd) @(negedge clk);
    pf_ack = 1;
    @(negedge clk);
    pf_ack = 0;
    if (e.trap) begin
      while (!exc_valid) @(negedge clk);
      if (poke) begin
        start_valid = 1; cur_pc = pc + 32'h100; op_value = 32'd0;
      end
      for (int i = 0; i < ackd; i++) begin
        check(exc_valid == 1'b1, {tag, " R9 exc held"}, 32'(exc_valid), 32'd1);
        check(exc_addr == e.addr, {tag, " R9 addr stable"}, exc_addr, e.addr);
        if (poke) check(start_ready == 1'b0, "R1 busy not ready", 32'(start_ready), 32'd0);
        @(negedge clk);
      end
      start_valid = 0;
      exc_ready = 1;
      @(negedge clk);
      exc_ready = 0;
      check(start_ready == 1'b1 && !exc_valid, {tag, " R9 back to idle"}, 32'(start_ready), 32'd1);
      if (poke) begin
        repeat (3) begin
          @(negedge clk);
          check(pf_req == 1'b0, "R1 busy start ignored", 32'(pf_req), 32'd0);
        end
      end
    end else begin
      repeat (6) @(negedge clk);
    end
  endtask

  // Monitor: observes outputs after each edge and compares with the scoreboard
  int  idle_cnt = 0, pf_cnt = 0, fwe_cnt = 0;
  bit  fn_seen = 0, pf_prev = 0, exc_prev = 0, done_prev = 0;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (pf_req && !pf_prev) pf_cnt++;
      pf_prev = pf_req;
      if (bus_idle) idle_cnt++;
      if (flag_we) begin fwe_cnt++; fn_seen = flag_n; end
      if (done && done_prev) check(0, "R10 done two cycles", 32'd1, 32'd0);
      if (done && exc_valid) check(0, "R10 done with trap", 32'd1, 32'd0);
      if (done || (exc_valid && !exc_prev)) begin
        if (sb.size() == 0) check(0, "R2 unexpected result", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(exc_valid == e.trap, {e.tag, " outcome"}, 32'(exc_valid), 32'(e.trap));
          check(idle_cnt == e.idles, {e.tag, " idle cycles"}, 32'(idle_cnt), 32'(e.idles));
          check(pf_cnt == 1, {e.tag, " R2 one prefetch"}, 32'(pf_cnt), 32'd1);
          check(fwe_cnt == (e.trap ? 1 : 0), {e.tag, " flag writes"}, 32'(fwe_cnt), 32'(e.trap));
          if (e.trap) begin
            check(fn_seen == e.fn, {e.tag, " flag_n"}, 32'(fn_seen), 32'(e.fn));
            check(exc_addr == e.addr, {e.tag, " R8 addr"}, exc_addr, e.addr);
            check(exc_vector == 8'd6, {e.tag, " R8 vector"}, 32'(exc_vector), 32'd6);
          end
        end
        idle_cnt = 0; pf_cnt = 0; fwe_cnt = 0;
      end
      exc_prev = exc_valid;
      done_prev = done;
    end
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(start_ready && !pf_req && !bus_idle && !flag_we && !exc_valid && !done,
          "R11 reset outputs", {26'd0, start_ready, pf_req, bus_idle, flag_we, exc_valid, done}, 32'h20);
    run_chk(32'd5,   32'd10,  2'd2, 32'h1000, 0, 1, "R4 in range", 0);
    run_chk(32'd10,  32'd10,  2'd2, 32'h1010, 2, 1, "R4 at bound", 0);
    run_chk(32'd0,   32'd0,   2'd2, 32'h1020, 1, 1, "R4 zero", 0);
    run_chk(32'd11,  32'd10,  2'd2, 32'h2000, 0, 2, "R5 over", 0);
    run_chk(32'hFFFF_FFFF, 32'd10, 2'd2, 32'h3000, 1, 0, "R6 under", 0);
    run_chk(32'hFFFF_FFF0, 32'hFFFF_FF00, 2'd2, 32'h4000, 0, 1, "R7 both", 0);
    run_chk(32'h0000_00FF, 32'd10, 2'd0, 32'h5000, 0, 1, "R3 byte neg", 0);
    run_chk(32'h1234_5605, 32'hAB00_0007, 2'd0, 32'h5010, 0, 1, "R3 byte upper ignored", 0);
    run_chk(32'h0000_8000, 32'h0000_7FFF, 2'd1, 32'h6000, 0, 1, "R3 word neg", 0);
    run_chk(32'h0000_8000, 32'h0001_0000, 2'd2, 32'h6010, 0, 1, "R3 long pos", 0);
    run_chk(32'h0000_0050, 32'h0000_0080, 2'd0, 32'h6020, 0, 1, "R3 byte bound neg R5", 0);
    run_chk(32'd20,  32'd3,   2'd3, 32'h7000, 0, 4, "R1 busy poke", 1);
    run_chk(32'd2,   32'd3,   2'd2, 32'h0000_0002, 0, 1, "R4 after poke", 0);
    run_chk(32'd9,   32'd3,   2'd2, 32'h0000_0002, 0, 1, "R8 pc wrap", 0);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 scoreboard drained", 32'(sb.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule